// File: doc/BRIEF.md
# Quadrature Frequency Detector with Lock Monitor

This block helps a clock recovery loop pull its local oscillator onto the frequency of incoming data. At every data transition, on rising and falling data edges alike, the in-phase and quadrature copies of the local clock are sampled. Those two bits are delivered to the block together with a one-cycle transition strobe in the system clock domain. The two bits name a quadrant of the local clock phase.

When the quadrant advances by one position between two strobes, the local clock is running slow and the block raises an up pulse. When the quadrant moves back by one position, the clock is running fast and the block raises a down pulse. When the quadrant does not move, the frequencies match and both outputs stay neutral. A jump of two positions has an ambiguous sign, so it also leaves both outputs neutral.

A lock flag tracks how steady the quadrant is. Any quadrant movement clears the flag at once. The flag is raised only when two conditions hold: a settling delay, counted in system clock cycles, has elapsed since the last movement, and a minimum number of motionless transitions has been seen. When no transitions arrive, nothing is measured, so the flag holds its value.

Top module: `quad_freq_detector`

## Requirements
- R1: While reset is asserted and after it is released, `upPulse`, `downPulse` and `lockFlag` are low until a strobe or the settling delay changes them.
- R2: The quadrant order is 00, 01, 11, 10 and back to 00, written as {iSample,qSample}. If a strobe's quadrant is one position forward of the previous strobe's quadrant, `upPulse` is high for exactly one cycle: the cycle after the clock edge that samples the strobe.
- R3: If a strobe's quadrant is one position backward of the previous strobe's quadrant, `downPulse` is high for exactly one cycle: the cycle after the sampling edge.
- R4: Both pulses stay low in four cases: a repeated quadrant, a two-position jump, the first strobe after reset (which only stores the quadrant), and any cycle without a strobe.
- R5: A strobe that shows any quadrant movement, including a two-position jump, drives `lockFlag` low at the same edge that samples it.
- R6: `lockFlag` goes high at the first clock edge where two conditions both hold: at least SETTLE_CYCLES edges have passed since the last movement (or since reset), and at least QUIET_RUN motionless strobes have been seen since then.
- R7: While no strobes arrive, `lockFlag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edgeStrobe | input | 1 | One-cycle pulse marking a data transition |
| iSample | input | 1 | In-phase local clock sampled at the transition |
| qSample | input | 1 | Quadrature local clock sampled at the transition |
| upPulse | output | 1 | Local clock slow: raise frequency |
| downPulse | output | 1 | Local clock fast: lower frequency |
| lockFlag | output | 1 | Frequency lock indication |

## Verification
The main function is tried with four quadrant patterns. A full forward rotation through the wrap from 10 to 00 must give only up pulses, and a full backward rotation must give only down pulses, which separates the two polarities and catches a wrong Gray decode. A run of repeated quadrants and a pair of two-position jumps must both stay neutral, which separates a real step from no motion and from an ambiguous one. The lock flag is checked at the exact edge of the settling delay in two cases: when the motionless run finishes before the delay, and when it finishes after it. The bench also confirms that a long gap with no strobes leaves the flag set, and that a single step or jump clears it on the next cycle.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
  typedef enum logic [1:0] {
    ROT_STAY = 2'd0,
    ROT_FWD  = 2'd1,
    ROT_HALF = 2'd2,
    ROT_BACK = 2'd3
  } rotStep_t;

  typedef struct packed {
    logic loadQuad;
    logic clearCounts;
    logic bumpQuiet;
  } qfdStrobes_t;

  function automatic logic [1:0] quadIndex(input logic iBit, input logic qBit);
    return {iBit, iBit ^ qBit};
  endfunction
endpackage

// File: rtl/qfd_datapath.sv
module qfd_datapath
  import qfd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 80,
  parameter int QUIET_RUN     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iSample,
  input  logic        qSample,
  input  qfdStrobes_t strobes,
  output rotStep_t    stepKind,
  output logic        havePrev,
  output logic        settleFullNext,
  output logic        quietFullNext
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int QW = $clog2(QUIET_RUN + 1);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYCLES);
  localparam logic [QW-1:0] QUIET_MAX  = QW'(QUIET_RUN);

  logic [1:0]    prevIdx;
  logic [1:0]    curIdx;
  logic [SW-1:0] settleCnt, settleNext;
  logic [QW-1:0] quietCnt, quietNext;

  assign curIdx   = quadIndex(iSample, qSample);
  assign stepKind = rotStep_t'(curIdx - prevIdx);

  always_comb begin
    if (strobes.clearCounts) settleNext = '0;
    else if (settleCnt == SETTLE_MAX) settleNext = settleCnt;
    else settleNext = settleCnt + 1'b1;

    if (strobes.clearCounts) quietNext = '0;
    else if (strobes.bumpQuiet && quietCnt != QUIET_MAX) quietNext = quietCnt + 1'b1;
    else quietNext = quietCnt;
  end

  assign settleFullNext = (settleNext == SETTLE_MAX);
  assign quietFullNext  = (quietNext == QUIET_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevIdx   <= '0;
      havePrev  <= 1'b0;
      settleCnt <= '0;
      quietCnt  <= '0;
    end else begin
      if (strobes.loadQuad) begin
        prevIdx  <= curIdx;
        havePrev <= 1'b1;
      end
      settleCnt <= settleNext;
      quietCnt  <= quietNext;
    end
  end

  assert_settle_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settleCnt <= SETTLE_MAX);

  assert_quiet_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quietCnt <= QUIET_MAX);

  assert_clear_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearCounts |=> (settleCnt == '0 && quietCnt == '0));
endmodule

// File: rtl/qfd_control.sv
module qfd_control
  import qfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        edgeStrobe,
  input  rotStep_t    stepKind,
  input  logic        havePrev,
  input  logic        settleFullNext,
  input  logic        quietFullNext,
  output qfdStrobes_t strobes,
  output logic        upPulse,
  output logic        downPulse,
  output logic        lockFlag
);
  logic measured;
  logic moved;

  assign measured = edgeStrobe && havePrev;
  assign moved    = measured && (stepKind != ROT_STAY);

  always_comb begin
    strobes.loadQuad    = edgeStrobe;
    strobes.clearCounts = moved;
    strobes.bumpQuiet   = measured && (stepKind == ROT_STAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upPulse   <= 1'b0;
      downPulse <= 1'b0;
      lockFlag  <= 1'b0;
    end else begin
      upPulse   <= measured && (stepKind == ROT_FWD);
      downPulse <= measured && (stepKind == ROT_BACK);
      lockFlag  <= !moved && settleFullNext && quietFullNext;
    end
  end

  assert_updown_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(upPulse && downPulse));

  assert_idle_neutral_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !edgeStrobe |=> (!upPulse && !downPulse));

  assert_forward_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (measured && stepKind == ROT_FWD) |=> upPulse);

  assert_move_drops_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> !lockFlag);
endmodule

// File: rtl/quad_freq_detector.sv
module quad_freq_detector
  import qfd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 80,
  parameter int QUIET_RUN     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edgeStrobe,
  input  logic iSample,
  input  logic qSample,
  output logic upPulse,
  output logic downPulse,
  output logic lockFlag
);
  qfdStrobes_t strobes;
  rotStep_t    stepKind;
  logic        havePrev;
  logic        settleFullNext;
  logic        quietFullNext;

  qfd_datapath #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .QUIET_RUN    (QUIET_RUN)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .iSample       (iSample),
    .qSample       (qSample),
    .strobes       (strobes),
    .stepKind      (stepKind),
    .havePrev      (havePrev),
    .settleFullNext(settleFullNext),
    .quietFullNext (quietFullNext)
  );

  qfd_control u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .edgeStrobe    (edgeStrobe),
    .stepKind      (stepKind),
    .havePrev      (havePrev),
    .settleFullNext(settleFullNext),
    .quietFullNext (quietFullNext),
    .strobes       (strobes),
    .upPulse       (upPulse),
    .downPulse     (downPulse),
    .lockFlag      (lockFlag)
  );
endmodule

// File: tb/sim_quad_freq_detector.sv
module sim_quad_freq_detector;
  localparam int SETTLE = 20;
  localparam int QUIET  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edgeStrobe = 1'b0;
  logic iSample = 1'b0;
  logic qSample = 1'b0;
  logic upPulse, downPulse, lockFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct packed { logic up; logic dn; } expItem_t;
  expItem_t expQ[$];

  int  refPrev = 0;
  bit  refHave = 1'b0;

  always #4 clk = ~clk;

  quad_freq_detector #(.SETTLE_CYCLES(SETTLE), .QUIET_RUN(QUIET)) u0 (
    .clk(clk), .rst_n(rst_n), .edgeStrobe(edgeStrobe),
    .iSample(iSample), .qSample(qSample),
    .upPulse(upPulse), .downPulse(downPulse), .lockFlag(lockFlag)
  );

  function automatic int grayPos(input bit i, input bit q);
    case ({i, q})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one strobe, expected pulses pushed to the scoreboard
  task automatic strobeQuad(input bit i, input bit q);
    int cur, d;
    expItem_t e;
    cur = grayPos(i, q);
    d = (cur - refPrev + 4) % 4;
    e.up = refHave && (d == 1);
    e.dn = refHave && (d == 3);
    expQ.push_back(e);
    refPrev = cur;
    refHave = 1'b1;
    iSample = i;
    qSample = q;
    edgeStrobe = 1'b1;
    @(negedge clk);
    edgeStrobe = 1'b0;
  endtask

  // monitor: pops one expected item per sampled strobe
  always begin
    @(posedge clk);
    if (rst_n && edgeStrobe) begin
      expItem_t e;
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(1'b0, "R2/R3 scoreboard empty", 0, 1);
      end else begin
        e = expQ.pop_front();
        check(upPulse == e.up, "R2 upPulse", int'(upPulse), int'(e.up));
        check(downPulse == e.dn, "R3 downPulse", int'(downPulse), int'(e.dn));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(!upPulse && !downPulse && !lockFlag, "R1 in reset", int'({upPulse, downPulse, lockFlag}), 0);
    rst_n = 1'b1;
    idle(1);
    check(!upPulse && !downPulse && !lockFlag, "R1 after release", int'({upPulse, downPulse, lockFlag}), 0);

    // first strobe only loads (R4), then forward rotation with wrap (R2)
    strobeQuad(0, 0);
    strobeQuad(0, 1);
    strobeQuad(1, 1);
    strobeQuad(1, 0);
    strobeQuad(0, 0);
    idle(1);
    check(!upPulse, "R2 single-cycle up", int'(upPulse), 0);
    // backward rotation (R3)
    strobeQuad(1, 0);
    strobeQuad(1, 1);
    strobeQuad(0, 1);
    strobeQuad(0, 0);
    // still and two-position jumps (R4)
    strobeQuad(0, 0);
    strobeQuad(0, 0);
    strobeQuad(1, 1);
    strobeQuad(0, 0);
    strobeQuad(1, 0);
    strobeQuad(0, 1);
    idle(3);

    // R6: quiet run completes before the settling delay
    strobeQuad(0, 0);
    check(!lockFlag, "R5 step clears lock", int'(lockFlag), 0);
    for (int k = 0; k < QUIET; k++) strobeQuad(0, 0);
    idle(SETTLE - 1 - QUIET);
    check(!lockFlag, "R6 lock one edge early", int'(lockFlag), 0);
    idle(1);
    check(lockFlag, "R6 lock at settle edge", int'(lockFlag), 1);

    // R7: no strobes keeps lock, and no pulses (R4)
    idle(60);
    check(lockFlag, "R7 lock held without data", int'(lockFlag), 1);
    check(!upPulse && !downPulse, "R4 no strobe no pulse", int'({upPulse, downPulse}), 0);

    // R5: forward step drops lock immediately
    strobeQuad(0, 1);
    check(!lockFlag, "R5 lock drop on step", int'(lockFlag), 0);

    // R6: delay passes before quiet run is complete
    strobeQuad(0, 1);
    strobeQuad(0, 1);
    idle(SETTLE + 5);
    check(!lockFlag, "R6 lock waits for quiet run", int'(lockFlag), 0);
    for (int k = 0; k < QUIET - 3; k++) strobeQuad(0, 1);
    check(!lockFlag, "R6 quiet run one short", int'(lockFlag), 0);
    strobeQuad(0, 1);
    check(lockFlag, "R6 lock at last quiet strobe", int'(lockFlag), 1);

    // R5: a two-position jump also drops lock
    strobeQuad(1, 0);
    check(!lockFlag, "R5 lock drop on jump", int'(lockFlag), 0);
    idle(3);

    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule